// File: doc/BRIEF.md
# Serial Configuration Receiver for Filter Select

This block lets an external controller choose how a converter's averaging filter and its output port are set up. The controller sends one 16-bit frame over a write-only, three-wire serial link: an active-low select, a data line and a clock. The receiver pulls three bits out of that frame. One bit picks the serial output port. Two bits pick the down-sampling ratio of the filter. The receiver holds these bits as static levels until the next good frame arrives.

The controller is often software toggling general-purpose pins. Its clock edges can therefore be hundreds of system clocks apart and unevenly spaced. For this reason every link input is brought into the system clock domain through a flop chain. Edges are then found by comparing the synchronized level with its value one cycle earlier.

A separate level input tells the block that a controller is attached. While that input is low, the receiver ignores every link transition. A frame during which that input drops is thrown away as a whole.

Top module: `cfg_spi_rx`

## Requirements
- R1: While reset is asserted, and after it is released with no frame yet received, `filt_sel_o` is 1 and `dsel_o` is 2'b00.
- R2: A frame is 16 data bits, most significant bit first. Each bit is sampled on a rising edge of `spi_sck_i` while `spi_csn_i` is low. When `spi_csn_i` returns high, the outputs take these values: `filt_sel_o` = frame bit 15, `dsel_o[0]` = frame bit 10, `dsel_o[1]` = frame bit 9. Bit positions count from 0 at the last bit sent.
- R3: Frame bits other than 15, 10 and 9 have no effect on any output.
- R4: If `spi_csn_i` returns high after fewer than 16 or more than 16 rising clock edges, the frame is discarded and the outputs keep their previous values.
- R5: Rising edges of `spi_sck_i` while `spi_csn_i` is high are ignored. They do not count toward the next frame.
- R6: While `ctrl_present_i` is low, all link activity is ignored and the outputs hold.
- R7: If `ctrl_present_i` goes low at any time between the falling and rising edge of `spi_csn_i`, that frame is discarded, even if the input returns high before the frame ends.
- R8: The outputs change only when a valid frame is accepted. They keep their values during a frame, including after its sixteenth bit, until `spi_csn_i` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| ctrl_present_i | input | 1 | High when an external controller is attached; asynchronous |
| spi_csn_i | input | 1 | Frame select, active low; asynchronous |
| spi_mosi_i | input | 1 | Serial data, sampled on the serial clock rising edge; asynchronous |
| spi_sck_i | input | 1 | Serial clock, idle low; asynchronous |
| filt_sel_o | output | 1 | 1 selects the filtered output port, 0 the no-latency port |
| dsel_o | output | 2 | Down-sampling select, {SEL1, SEL0} |

## Verification
The assertions take for granted that every link input holds each level for several system clocks. This means the synchronizer never merges two edges, and the data line is steady before the clock rises that samples it. The bench drives each link phase for six system clocks and changes the data line one full phase before the clock edge. It also waits a few extra cycles after each frame before it samples the outputs. Control pins are changed only on the falling system clock edge, so every pin that is driven is also settled when sampled.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;

  // Frame geometry and field positions (bit 0 = last bit on the wire)
  localparam int unsigned FRAME_BITS_DEF  = 16;
  localparam int unsigned FILT_POS_DEF    = 15;
  localparam int unsigned SEL0_POS_DEF    = 10;
  localparam int unsigned SEL1_POS_DEF    = 9;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // Index of each pin inside the synchronizer vector
  localparam int unsigned PIN_SCK   = 0;
  localparam int unsigned PIN_MOSI  = 1;
  localparam int unsigned PIN_PRES  = 2;
  localparam int unsigned PIN_CSN   = 3;
  localparam int unsigned PIN_COUNT = 4;

  // Idle levels: select high, everything else low
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 4'b1000;

  typedef struct packed {
    logic       filt_sel;
    logic [1:0] dsel;      // {SEL1, SEL0}
  } cfg_t;

  localparam cfg_t CFG_RESET = '{filt_sel: 1'b1, dsel: 2'b00};

endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
  parameter int unsigned          WIDTH   = 4,
  parameter int unsigned          STAGES  = 2,
  parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);

  // STAGES synchronizing flops plus one history flop for edge detection
  localparam int unsigned DEPTH = STAGES + 1;

  logic [WIDTH-1:0] stg_q [DEPTH];
  logic [WIDTH-1:0] stg_d [DEPTH];

  always_comb begin
    stg_d[0] = async_i;
    for (int s = 1; s < DEPTH; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[g] <= RST_VAL;
      end else begin
        stg_q[g] <= stg_d[g];
      end
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign prev_o = stg_q[STAGES];

endmodule

// File: rtl/cfg_spi_frame.sv
module cfg_spi_frame #(
  parameter int unsigned FRAME_BITS = 16,
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  present_i,
  input  logic                  csn_lvl_i,
  input  logic                  csn_fall_i,
  input  logic                  csn_rise_i,
  input  logic                  sck_rise_i,
  input  logic                  mosi_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic [CNT_W-1:0]      cnt_o,
  output logic                  commit_o
);

  // One past a full frame marks "no valid frame in progress"
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_BAD  = CNT_W'(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  sh_en;

  assign sh_en = present_i && !csn_lvl_i && !csn_fall_i && sck_rise_i;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (!present_i) begin
      cnt_d = CNT_BAD;
    end else if (csn_fall_i) begin
      cnt_d = '0;
    end else if (sh_en) begin
      sh_d = {sh_q[FRAME_BITS-2:0], mosi_i};
      if (cnt_q != CNT_BAD) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= CNT_BAD;
    end else begin
      if (sh_en) begin
        sh_q <= sh_d;
      end
      cnt_q <= cnt_d;
    end
  end

  assign commit_o = present_i && csn_rise_i && (cnt_q == CNT_FULL);
  assign frame_o  = sh_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/cfg_spi_hold.sv
module cfg_spi_hold
  import cfg_spi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic commit_i,
  input  logic filt_bit_i,
  input  logic sel0_bit_i,
  input  logic sel1_bit_i,
  output cfg_t cfg_o
);

  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (commit_i) begin
      cfg_d.filt_sel = filt_bit_i;
      cfg_d.dsel     = {sel1_bit_i, sel0_bit_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (commit_i) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/cfg_spi_rx.sv
module cfg_spi_rx
  import cfg_spi_pkg::*;
#(
  parameter int unsigned FRAME_BITS  = FRAME_BITS_DEF,
  parameter int unsigned FILT_POS    = FILT_POS_DEF,
  parameter int unsigned SEL0_POS    = SEL0_POS_DEF,
  parameter int unsigned SEL1_POS    = SEL1_POS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_present_i,
  input  logic       spi_csn_i,
  input  logic       spi_mosi_i,
  input  logic       spi_sck_i,
  output logic       filt_sel_o,
  output logic [1:0] dsel_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);

  logic [PIN_COUNT-1:0]  pins_a, pins_lvl, pins_prev;
  logic                  csn_s, present_s, mosi_s;
  logic                  csn_rise, csn_fall, sck_rise;
  logic [FRAME_BITS-1:0] frame_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  commit;
  cfg_t                  cfg_q;

  always_comb begin
    pins_a           = '0;
    pins_a[PIN_SCK]  = spi_sck_i;
    pins_a[PIN_MOSI] = spi_mosi_i;
    pins_a[PIN_PRES] = ctrl_present_i;
    pins_a[PIN_CSN]  = spi_csn_i;
  end

  cfg_spi_sync #(
    .WIDTH   (PIN_COUNT),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_a),
    .lvl_o   (pins_lvl),
    .prev_o  (pins_prev)
  );

  assign csn_s     = pins_lvl[PIN_CSN];
  assign present_s = pins_lvl[PIN_PRES];
  assign mosi_s    = pins_lvl[PIN_MOSI];
  assign csn_rise  =  pins_lvl[PIN_CSN] & ~pins_prev[PIN_CSN];
  assign csn_fall  = ~pins_lvl[PIN_CSN] &  pins_prev[PIN_CSN];
  assign sck_rise  =  pins_lvl[PIN_SCK] & ~pins_prev[PIN_SCK];

  cfg_spi_frame #(
    .FRAME_BITS (FRAME_BITS)
  ) frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .present_i  (present_s),
    .csn_lvl_i  (csn_s),
    .csn_fall_i (csn_fall),
    .csn_rise_i (csn_rise),
    .sck_rise_i (sck_rise),
    .mosi_i     (mosi_s),
    .frame_o    (frame_q),
    .cnt_o      (cnt_q),
    .commit_o   (commit)
  );

  cfg_spi_hold hold_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_i   (commit),
    .filt_bit_i (frame_q[FILT_POS]),
    .sel0_bit_i (frame_q[SEL0_POS]),
    .sel1_bit_i (frame_q[SEL1_POS]),
    .cfg_o      (cfg_q)
  );

  assign filt_sel_o = cfg_q.filt_sel;
  assign dsel_o     = cfg_q.dsel;

endmodule

// File: rtl/cfg_spi_rx_chk.sv
module cfg_spi_rx_chk #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned FILT_POS   = 15,
  parameter int unsigned SEL0_POS   = 10,
  parameter int unsigned SEL1_POS   = 9,
  parameter int unsigned CNT_W      = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  csn_s,
  input logic                  present_s,
  input logic                  commit,
  input logic [FRAME_BITS-1:0] frame_q,
  input logic [CNT_W-1:0]      cnt_q,
  input logic                  filt_sel_o,
  input logic [1:0]            dsel_o
);

  localparam logic [CNT_W-1:0] CNT_BAD = CNT_W'(FRAME_BITS + 1);

  // R2: accepted frame drives the port select from its top bit
  a_r2_commit_filt: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> filt_sel_o == $past(frame_q[FILT_POS]));

  // R3: only the two select bits reach the ratio output
  a_r3_commit_sel: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> dsel_o == {$past(frame_q[SEL1_POS]), $past(frame_q[SEL0_POS])});

  // R4: bit counter never passes the discard marker
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_BAD);

  // R5: no shifting while the select is high
  a_r5_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_s && present_s) |=> $stable(frame_q));

  // R6: absent controller leaves the outputs alone
  a_r6_absent_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !present_s |=> $stable({filt_sel_o, dsel_o}));

  // R7: absence spoils the frame in progress
  a_r7_absent_poison: assert property (@(posedge clk) disable iff (!rst_n)
    !present_s |=> cnt_q == CNT_BAD);

  // R8: outputs move only on an accepted frame
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({filt_sel_o, dsel_o}));

endmodule

bind cfg_spi_rx cfg_spi_rx_chk #(
  .FRAME_BITS (FRAME_BITS),
  .FILT_POS   (FILT_POS),
  .SEL0_POS   (SEL0_POS),
  .SEL1_POS   (SEL1_POS),
  .CNT_W      (CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .csn_s      (csn_s),
  .present_s  (present_s),
  .commit     (commit),
  .frame_q    (frame_q),
  .cnt_q      (cnt_q),
  .filt_sel_o (filt_sel_o),
  .dsel_o     (dsel_o)
);

// File: tb/cfg_spi_rx_tb.sv
module cfg_spi_rx_tb_top;

  localparam int PH = 6;   // system clocks per link phase

  typedef struct packed {
    logic [31:0] data;
    logic [5:0]  nbits;
    logic        pres;
    logic        exp_filt;
    logic [1:0]  exp_dsel;
    logic [7:0]  req;      // requirement number for messages
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h8000, 6'd16, 1'b1, 1'b1, 2'b00, 8'd2},
    '{32'h0400, 6'd16, 1'b1, 1'b0, 2'b01, 8'd2},
    '{32'h0200, 6'd16, 1'b1, 1'b0, 2'b10, 8'd2},
    '{32'h8600, 6'd16, 1'b1, 1'b1, 2'b11, 8'd2},
    '{32'h79FF, 6'd16, 1'b1, 1'b0, 2'b00, 8'd3},
    '{32'hFFFF, 6'd16, 1'b1, 1'b1, 2'b11, 8'd3},
    '{32'h0000, 6'd15, 1'b1, 1'b1, 2'b11, 8'd4},
    '{32'h0000, 6'd17, 1'b1, 1'b1, 2'b11, 8'd4},
    '{32'h0000, 6'd16, 1'b0, 1'b1, 2'b11, 8'd6},
    '{32'h0400, 6'd16, 1'b1, 1'b0, 2'b01, 8'd2}
  };

  logic       clk;
  logic       rst_n;
  logic       present, csn, mosi, sck;
  logic       filt_sel;
  logic [1:0] dsel;
  int         n_chk, n_bad;
  bit         done;

  cfg_spi_rx dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl_present_i (present),
    .spi_csn_i      (csn),
    .spi_mosi_i     (mosi),
    .spi_sck_i      (sck),
    .filt_sel_o     (filt_sel),
    .dsel_o         (dsel)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic ef, input logic [1:0] ed);
    n_chk++;
    if (filt_sel !== ef || dsel !== ed) begin
      n_bad++;
      $display("FAIL %s: got filt=%b dsel=%b, expected filt=%b dsel=%b",
               req, filt_sel, dsel, ef, ed);
    end
  endtask

  task automatic cs_low();
    csn = 1'b0; wt(PH);
  endtask

  task automatic cs_high();
    csn = 1'b1; wt(PH + 4);
  endtask

  task automatic bits_out(input logic [31:0] d, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = d[i]; wt(PH);
      sck = 1'b1;  wt(PH);
      sck = 1'b0;  wt(PH);
    end
  endtask

  task automatic frame(input logic [31:0] d, input int n);
    cs_low();
    bits_out(d, n);
    cs_high();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b1; present = 1'b0; csn = 1'b1; mosi = 1'b0; sck = 1'b0;
    #1 rst_n = 1'b0;
    wt(4);
    check("R1 during reset", 1'b1, 2'b00);
    rst_n = 1'b1;
    present = 1'b1;
    wt(8);
    check("R1 after reset", 1'b1, 2'b00);

    // Table walk: R2, R3, R4, R6
    for (int v = 0; v < NV; v++) begin
      present = VECS[v].pres; wt(8);
      frame(VECS[v].data, int'(VECS[v].nbits));
      present = 1'b1; wt(8);
      check($sformatf("R%0d vector %0d", VECS[v].req, v),
            VECS[v].exp_filt, VECS[v].exp_dsel);
    end

    // R5: clock edges with select high are ignored
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1; wt(PH); sck = 1'b1; wt(PH); sck = 1'b0; wt(PH);
    end
    wt(8);
    check("R5 idle clocks hold outputs", 1'b0, 2'b01);
    frame(32'h8200, 16);
    check("R5 frame after idle clocks", 1'b1, 2'b10);

    // R8: no change after 16 bits until select rises
    cs_low();
    bits_out(32'h0400, 16);
    wt(8);
    check("R8 before select rises", 1'b1, 2'b10);
    cs_high();
    check("R8 after select rises", 1'b0, 2'b01);

    // R7: controller drop mid-frame spoils the frame
    cs_low();
    bits_out(32'h86, 8);
    present = 1'b0; wt(10);
    present = 1'b1; wt(10);
    bits_out(32'h00, 8);
    cs_high();
    check("R7 frame discarded", 1'b0, 2'b01);
    frame(32'hC400, 16);
    check("R7 next frame accepted", 1'b1, 2'b01);

    // R1: reset mid-run restores defaults
    rst_n = 1'b0; wt(3);
    check("R1 reset mid-run", 1'b1, 2'b00);
    rst_n = 1'b1; wt(8);
    check("R1 reset released", 1'b1, 2'b00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule